// File: doc/BRIEF.md
# Word-Line Direct-Mapped Data Cache with Per-Access Write Policy

This block sits between a processor load/store port and a simple main-memory port. It is a direct-mapped data cache. Each line stores one 32-bit word together with its tag, a valid flag and a dirty flag. The byte address is split into three fields. The low two bits select a byte within the word and the cache ignores them. The next `IDX_W` bits choose the line. The remaining upper bits form the tag.

Every request carries a region attribute, `req_wt`, that picks the write policy for that access alone.

- Write-back handling keeps modified words in the array and marks the line dirty. A dirty line is written out to memory only when another address displaces it.
- Write-through handling sends every write to an external write-queue port, and the line is not left dirty.

Both policies share the one array. A hit answers after a fixed two-cycle latency. A miss holds the processor port stalled while the cache runs its memory transactions: a write-back of a dirty victim first, then a refill where one is needed.

Top module: `dmc_cache`

## Requirements
- R1: Line index is `req_addr[IDX_W+1:2]` and tag is `req_addr[31:IDX_W+2]`. Bits [1:0] never affect the outcome. Every address driven on `mem_addr` and `wq_addr` has bits [1:0] equal to 0.
- R2: After reset, `req_ready` is 1 and `rsp_valid`, `mem_valid` and `wq_valid` are 0. Every line is invalid, so the first read of any address causes one memory read.
- R3: A read that hits raises `rsp_valid` for one cycle exactly two rising edges after the accepting edge. It returns the most recently written word for that address and causes no memory or write-queue transaction.
- R4: A read miss whose line is invalid or clean issues exactly one memory read (`mem_write`=0) of the word-aligned address. It returns that word and installs it clean, so an immediate re-read hits.
- R5: A write-back write (`req_write`=1, `req_wt`=0) that hits updates the stored word and marks the line dirty, with no memory or write-queue transaction.
- R6: A miss whose line is valid and dirty first issues a memory write (`mem_write`=1) of the old word to the address built from the old tag and the index. Only after that write is acknowledged does it issue the read of the new address.
- R7: A write-back write miss installs the written word as a dirty line without any memory read. The only memory transaction it may cause is the write-back of a dirty victim.
- R8: A write-through write (`req_write`=1, `req_wt`=1) produces one write-queue transfer carrying the word-aligned address and the data, and no memory-port transaction. On a hit it also updates the stored word and leaves the line clean, so a later eviction of that line causes no write-back.
- R9: A write-through write miss does not allocate. The line keeps its previous contents, and a later read of the written address misses.
- R10: Two addresses that differ by a multiple of 2^(IDX_W+2) bytes share a line and displace each other.
- R11: `req_ready` is 1 only while the block is idle. It stays 0 from acceptance until the response, including every cycle in which `mem_valid` or `wq_valid` is high.
- R12: Each accepted request produces exactly one single-cycle `rsp_valid` pulse. A raised `mem_valid` or `wq_valid` holds its address, data and direction steady until `mem_ack` or `wq_ready` completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | Region attribute: 1 = write-through, 0 = write-back |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with `rsp_valid` on a load |
| mem_valid | output | 1 | Memory transaction request |
| mem_write | output | 1 | 1 = write-back of a victim, 0 = refill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Victim word being written back |
| mem_ack | input | 1 | One-cycle completion of the memory transaction |
| mem_rdata | input | 32 | Refill word, valid with `mem_ack` on a read |
| wq_valid | output | 1 | Write-through store offered to the write queue |
| wq_ready | input | 1 | Write queue takes the store |
| wq_addr | output | 32 | Word-aligned store address |
| wq_data | output | 32 | Store data |

## Verification
The assertions assume that `mem_ack` pulses for a single cycle, and only while `mem_valid` is high. They also assume that `wq_ready` only completes a transfer that is being offered. A further assumption is that whatever drains the write queue makes the store visible to later memory reads before the cache refills that address. The bench's memory model follows these rules. It answers the memory port and the queue port after a random delay of zero to two cycles. It commits queued stores to its backing memory at the moment it accepts them. Its addresses stay within 1 KiB, so that many addresses alias onto each of the 16 lines and byte-offset bits vary at random.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL,
        ST_WQ,
        ST_RESP
    } ctrl_state_t;

    typedef struct packed {
        logic              write;
        logic              wt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cpu_req_t;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return a & ~ADDR_W'((1 << OFF_W) - 1);
    endfunction

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_dirty,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
            end else if (sel) begin
                valid_q[i] <= 1'b1;
                dirty_q[i] <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    // R2: the cycle after reset finds every line invalid and clean
    a_r2_lines_cold: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0 && dirty_q == '0));

endmodule

// File: rtl/dmc_hit_cmp.sv
module dmc_hit_cmp
    import dmc_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             line_valid,
    input  logic             line_dirty,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit,
    output logic             victim_dirty
);
    always_comb begin
        hit          = line_valid && (line_tag == req_tag);
        victim_dirty = line_valid && line_dirty && !hit;
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  cpu_req_t          req_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wq_valid,
    input  logic              wq_ready,
    output logic [ADDR_W-1:0] wq_addr,
    output logic [DATA_W-1:0] wq_data,
    output logic [IDX_W-1:0]  look_idx,
    output logic [TAG_W-1:0]  look_tag,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              st_we,
    output logic              st_dirty,
    output logic [DATA_W-1:0] st_data
);
    ctrl_state_t       state_q, state_d;
    cpu_req_t          req_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;
    logic              load_rd;
    logic              wt_store;

    assign look_idx = req_q.addr[IDX_W+OFF_W-1:OFF_W];
    assign look_tag = req_q.addr[ADDR_W-1:IDX_W+OFF_W];
    assign wt_store = req_q.write && req_q.wt;

    assign req_ready = (state_q == ST_IDLE);
    assign mem_valid = (state_q == ST_WBACK) || (state_q == ST_FILL);
    assign mem_write = (state_q == ST_WBACK);
    assign mem_addr  = (state_q == ST_WBACK) ? {line_tag, look_idx, OFF_W'(0)}
                                             : word_align(req_q.addr);
    assign mem_wdata = line_data;
    assign wq_valid  = (state_q == ST_WQ);
    assign wq_addr   = word_align(req_q.addr);
    assign wq_data   = req_q.wdata;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;

    always_comb begin
        state_d  = state_q;
        st_we    = 1'b0;
        st_dirty = 1'b0;
        st_data  = req_q.wdata;
        load_rd  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (wt_store) begin
                    st_we   = hit;
                    state_d = ST_WQ;
                end else if (hit) begin
                    st_we    = req_q.write;
                    st_dirty = 1'b1;
                    load_rd  = !req_q.write;
                    state_d  = ST_RESP;
                end else if (victim_dirty) begin
                    state_d = ST_WBACK;
                end else if (req_q.write) begin
                    st_we    = 1'b1;
                    st_dirty = 1'b1;
                    state_d  = ST_RESP;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    if (req_q.write) begin
                        st_we    = 1'b1;
                        st_dirty = 1'b1;
                        state_d  = ST_RESP;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                st_data = mem_rdata;
                if (mem_ack) begin
                    st_we   = 1'b1;
                    load_rd = 1'b1;
                    state_d = ST_RESP;
                end
            end
            ST_WQ: begin
                if (wq_ready) state_d = ST_RESP;
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rsp_q   <= 1'b0;
            rdata_q <= '0;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            rsp_q   <= (state_q == ST_RESP);
            if (state_q == ST_IDLE && req_valid) req_q <= req_in;
            if (load_rd) rdata_q <= (state_q == ST_FILL) ? mem_rdata : line_data;
        end
    end

    // R11: no request is taken while a memory or queue transfer is pending
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_valid || wq_valid) |-> !req_ready);

    // R1: addresses leaving the block are word aligned
    a_r1_mem_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // R12: a memory request holds until acknowledged
    a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                     && $stable(mem_wdata)));

    // R12: a queue offer holds until taken
    a_r12_wq_hold: assert property (@(posedge clk) disable iff (rst)
        (wq_valid && !wq_ready) |=> (wq_valid && $stable(wq_addr) && $stable(wq_data)));

    // R12: the response is a single-cycle pulse
    a_r12_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R6: an acknowledged write-back of a load miss is followed by the refill read
    a_r6_fill_after_wb: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && mem_ack && !req_q.write) |=> (mem_valid && !mem_write));

    // R3: a hit that is not a write-through store stays off both external ports
    a_r3_hit_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOKUP && hit && !wt_store) |=> (!mem_valid && !wq_valid));

    // R8: write-through stores never use the memory port
    a_r8_wt_no_mem: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && wt_store) |-> !mem_valid);

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic        req_wt,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        wq_valid,
    input  logic        wq_ready,
    output logic [31:0] wq_addr,
    output logic [31:0] wq_data
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    cpu_req_t          req_in;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic              hit, victim_dirty;
    logic              st_we, st_dirty;
    logic [DATA_W-1:0] st_data;

    assign req_in = '{write: req_write, wt: req_wt, addr: req_addr, wdata: req_wdata};

    dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (look_idx),
        .rd_valid (line_valid),
        .rd_dirty (line_dirty),
        .rd_tag   (line_tag),
        .rd_data  (line_data),
        .wr_en    (st_we),
        .wr_idx   (look_idx),
        .wr_tag   (look_tag),
        .wr_dirty (st_dirty),
        .wr_data  (st_data)
    );

    dmc_hit_cmp #(.TAG_W(TAG_W)) cmp_i (
        .line_valid   (line_valid),
        .line_dirty   (line_dirty),
        .line_tag     (line_tag),
        .req_tag      (look_tag),
        .hit          (hit),
        .victim_dirty (victim_dirty)
    );

    dmc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_in       (req_in),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .mem_valid    (mem_valid),
        .mem_write    (mem_write),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .wq_valid     (wq_valid),
        .wq_ready     (wq_ready),
        .wq_addr      (wq_addr),
        .wq_data      (wq_data),
        .look_idx     (look_idx),
        .look_tag     (look_tag),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .line_tag     (line_tag),
        .line_data    (line_data),
        .st_we        (st_we),
        .st_dirty     (st_dirty),
        .st_data      (st_data)
    );

endmodule

// File: tb/dmc_cache_tb.sv
`timescale 1ns/1ps
module dmc_cache_tb_top;
    localparam int IDX_W = 4;
    localparam logic [31:0] SPAN = 32'(1 << (IDX_W + 2));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wt = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        wq_valid;
    logic        wq_ready = 1'b0;
    logic [31:0] wq_addr, wq_data;

    always #2 clk = ~clk;

    dmc_cache #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wt(req_wt), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_addr(wq_addr), .wq_data(wq_data)
    );

    int nchk = 0, nfail = 0, nops = 0, nrsp = 0, busy_bad = 0;
    int mdelay = 0, wdelay = 0, seed_dummy;
    logic [31:0] bmem [256];
    logic [31:0] refm [256];
    logic        mlog_w [4096];
    logic [31:0] mlog_a [4096];
    logic [31:0] mlog_d [4096];
    int          mlog_n = 0;
    logic [31:0] wlog_a [4096];
    logic [31:0] wlog_d [4096];
    int          wlog_n = 0;

    function automatic logic [31:0] init_word(int i);
        return 32'h1000_0000 + 32'(i) * 32'h0001_0101 ^ 32'h0000_005A;
    endfunction

    // memory and write-queue model, one transfer per acknowledgement
    always @(negedge clk) begin
        if (rst) begin
            mem_ack  = 1'b0;
            wq_ready = 1'b0;
        end else begin
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_valid) begin
                if (mdelay != 0) mdelay--;
                else begin
                    if (mem_write) bmem[mem_addr[9:2]] = mem_wdata;
                    else mem_rdata = bmem[mem_addr[9:2]];
                    mlog_w[mlog_n] = mem_write;
                    mlog_a[mlog_n] = mem_addr;
                    mlog_d[mlog_n] = mem_wdata;
                    mlog_n++;
                    mem_ack = 1'b1;
                    mdelay = int'($urandom % 3);
                end
            end
            if (wq_ready) wq_ready = 1'b0;
            else if (wq_valid) begin
                if (wdelay != 0) wdelay--;
                else begin
                    bmem[wq_addr[9:2]] = wq_data;
                    wlog_a[wlog_n] = wq_addr;
                    wlog_d[wlog_n] = wq_data;
                    wlog_n++;
                    wq_ready = 1'b1;
                    wdelay = int'($urandom % 3);
                end
            end
            if ((mem_valid || wq_valid) && req_ready) busy_bad++;
            if (rsp_valid) nrsp++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input bit w, input bit wt, input logic [31:0] a,
                         input logic [31:0] d, output logic [31:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_wt = wt; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        nops++;
        if (w) refm[a[9:2]] = d;
        lat = 0;
        rd = '0;
        while (lat < 1000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (rsp_valid) begin
                rd = rsp_rdata;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        summary();
    end

    initial begin
        logic [31:0] rd;
        int lat, m0, w0;
        logic [31:0] A, B, C, D, E;
        seed_dummy = int'($urandom(32'd1789));
        for (int i = 0; i < 256; i++) begin
            bmem[i] = init_word(i);
            refm[i] = init_word(i);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: idle outputs after reset
        check(req_ready == 1'b1, "R2", "ready after reset", 32'(req_ready), 1);
        check({rsp_valid, mem_valid, wq_valid} == 3'b000, "R2", "outputs quiet",
              32'({rsp_valid, mem_valid, wq_valid}), 0);

        A = 32'h0000_0104; B = A + SPAN; C = A + 2 * SPAN; D = A + 3 * SPAN; E = A + 4 * SPAN;

        // R2/R4/R1: cold read with nonzero offset
        m0 = mlog_n;
        do_op(0, 0, A | 32'h2, 0, rd, lat);
        check(mlog_n == m0 + 1 && !mlog_w[m0], "R2", "cold read one mem read", 32'(mlog_n - m0), 1);
        check(mlog_a[m0] == A, "R1", "aligned refill address", mlog_a[m0], A);
        check(rd == refm[A[9:2]], "R4", "miss data", rd, refm[A[9:2]]);

        // R3: re-read hits in two cycles, quiet
        m0 = mlog_n; w0 = wlog_n;
        do_op(0, 0, A | 32'h1, 0, rd, lat);
        check(lat == 2, "R3", "hit latency", 32'(lat), 2);
        check(mlog_n == m0 && wlog_n == w0, "R3", "hit no traffic", 32'(mlog_n - m0), 0);
        check(rd == refm[A[9:2]], "R3", "hit data", rd, refm[A[9:2]]);

        // R5: write-back write hit
        m0 = mlog_n; w0 = wlog_n;
        do_op(1, 0, A, 32'hDEAD_0001, rd, lat);
        check(mlog_n == m0 && wlog_n == w0, "R5", "wb hit no traffic", 32'(mlog_n - m0 + wlog_n - w0), 0);
        do_op(0, 0, A, 0, rd, lat);
        check(rd == 32'hDEAD_0001 && lat == 2, "R5", "wb hit data", rd, 32'hDEAD_0001);

        // R6/R10: conflicting read evicts dirty word, write-back first
        m0 = mlog_n;
        do_op(0, 0, B, 0, rd, lat);
        check(mlog_n == m0 + 2, "R6", "two mem transfers", 32'(mlog_n - m0), 2);
        check(mlog_w[m0] && mlog_a[m0] == A && mlog_d[m0] == 32'hDEAD_0001, "R6",
              "victim written first", mlog_d[m0], 32'hDEAD_0001);
        check(!mlog_w[m0+1] && mlog_a[m0+1] == B, "R6", "then refill read", mlog_a[m0+1], B);
        check(rd == refm[B[9:2]], "R10", "alias data", rd, refm[B[9:2]]);
        m0 = mlog_n;
        do_op(0, 0, A, 0, rd, lat);
        check(mlog_n == m0 + 1 && !mlog_w[m0], "R10", "alias evicted, clean refill", 32'(mlog_n - m0), 1);
        check(rd == 32'hDEAD_0001, "R10", "written-back word", rd, 32'hDEAD_0001);

        // R8: write-through hit
        m0 = mlog_n; w0 = wlog_n;
        do_op(1, 1, A | 32'h3, 32'hBEEF_0002, rd, lat);
        check(wlog_n == w0 + 1 && wlog_a[w0] == A && wlog_d[w0] == 32'hBEEF_0002, "R8",
              "queue store", wlog_d[w0], 32'hBEEF_0002);
        check(mlog_n == m0, "R8", "no mem traffic", 32'(mlog_n - m0), 0);
        do_op(0, 0, A, 0, rd, lat);
        check(rd == 32'hBEEF_0002 && lat == 2, "R8", "hit updated", rd, 32'hBEEF_0002);
        m0 = mlog_n;
        do_op(0, 0, B, 0, rd, lat);
        check(mlog_n == m0 + 1 && !mlog_w[m0], "R8", "clean after wt, no write-back", 32'(mlog_n - m0), 1);

        // R9: write-through miss does not allocate
        m0 = mlog_n; w0 = wlog_n;
        do_op(1, 1, C, 32'hCAFE_0003, rd, lat);
        check(wlog_n == w0 + 1 && mlog_n == m0, "R9", "wt miss queue only", 32'(wlog_n - w0), 1);
        do_op(0, 0, B, 0, rd, lat);
        check(lat == 2 && rd == refm[B[9:2]], "R9", "old line kept", 32'(lat), 2);
        m0 = mlog_n;
        do_op(0, 0, C, 0, rd, lat);
        check(mlog_n == m0 + 1 && rd == 32'hCAFE_0003, "R9", "later read misses", rd, 32'hCAFE_0003);

        // R7: write-back write miss allocates without reading
        m0 = mlog_n;
        do_op(1, 0, D, 32'hD00D_0004, rd, lat);
        check(mlog_n == m0, "R7", "clean victim, no mem", 32'(mlog_n - m0), 0);
        do_op(0, 0, D, 0, rd, lat);
        check(lat == 2 && rd == 32'hD00D_0004, "R7", "allocated dirty word", rd, 32'hD00D_0004);
        m0 = mlog_n;
        do_op(1, 0, E, 32'hE000_0005, rd, lat);
        check(mlog_n == m0 + 1 && mlog_w[m0] && mlog_a[m0] == D && mlog_d[m0] == 32'hD00D_0004,
              "R7", "only victim write-back", 32'(mlog_n - m0), 1);

        // random mix, reads compared with reference memory
        for (int k = 0; k < 600; k++) begin
            bit w, wt;
            logic [31:0] a, d;
            w  = 1'($urandom);
            wt = 1'($urandom);
            a  = {22'd0, 8'($urandom), 2'($urandom)};
            d  = $urandom;
            if (w) do_op(1, wt, a, d, rd, lat);
            else begin
                do_op(0, wt, a, 0, rd, lat);
                check(rd == refm[a[9:2]], "R4", "random read", rd, refm[a[9:2]]);
            end
        end

        repeat (3) @(negedge clk);
        check(busy_bad == 0, "R11", "ready while busy", 32'(busy_bad), 0);
        check(nrsp == nops, "R12", "one response per request", 32'(nrsp), 32'(nops));
        summary();
    end
endmodule